// File: doc/BRIEF.md
# SPI DMA Transfer Sequencer with CRC

This block sits between a serial shift engine and a DMA channel that works by request and acknowledge. Software programs a payload length and starts a transfer. The sequencer then does the rest:

- It asks the DMA for transmit words one at a time and passes each one to the shift engine.
- When the last payload word has gone out, it appends a CRC word on its own when CRC is on.
- On the receive side it collects returned words in a receive data register.
- It checks the trailing CRC against a value it computes over the received payload.

The programmed length counts payload words only. The trailing CRC word is not part of it. The received CRC word still lands in the receive data register like any other word, so the DMA or software has to take it out before the next transfer.

The CRC is CRC-8. It is computed MSB first, starts from zero, and uses a polynomial held in a register that resets to 0x07. Two single-cycle interrupt pulses mark progress: one at the half-way point of the received payload and one at the end of the transfer. A CRC mismatch raises a sticky error flag, which is cleared by writing a one to it.

Top module: `spi_dma_seq`

## Requirements
- R1: After reset, tx_req_o, rx_req_o, rx_full_o, busy_o, crc_err_o, half_irq_o, done_irq_o and eng_tx_valid_o are all 0.
- R2: tx_req_o is 1 exactly when tx_dma_en_i is 1, a transfer is active, the transmit holding register is empty and payload words remain to be written. It stays 0 during the CRC phase. A tx_wr_i is ignored when the holding register is full or no payload word remains. A transfer therefore accepts exactly len_i writes.
- R3: With CRC on, the word after the last payload word handed to the engine is the CRC of the transmitted payload, and it needs no further write. The engine receives len_i+1 words with CRC on and len_i words with it off.
- R4: The CRC is computed MSB first, with the accumulator starting at 0. For each bit, the feedback is the accumulator MSB xor the data bit; the accumulator shifts left and is xored with the polynomial when the feedback is 1. The polynomial register resets to 0x07. With that polynomial, the ASCII bytes "123456789" give 0xF4.
- R5: Every word returned by the engine during a transfer, the CRC word included, is loaded into rx_data_o and sets rx_full_o. rx_req_o equals rx_dma_en_i and rx_full_o taken together. rx_rd_i clears rx_full_o.
- R6: If the received CRC word differs from the CRC of the received payload, crc_err_o is set. It stays set until err_clr_i is pulsed. A matching CRC leaves crc_err_o unchanged.
- R7: half_irq_o pulses once when the received payload count reaches floor(len/2), provided that value is nonzero. done_irq_o pulses once when the last payload word is received (CRC off) or when the CRC word is received (CRC on). busy_o is 0 while done_irq_o is high.
- R8: Both CRC accumulators return to 0 at the end of a transfer and at its start, so each transfer's CRC depends only on its own payload.
- R9: A poly_wr_i while idle loads poly_i into the polynomial register. A poly_wr_i while busy is ignored.
- R10: start_i is ignored while busy or when len_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a transfer |
| len_i | input | LW | Payload word count, sampled on start |
| crc_en_i | input | 1 | Append and check a CRC word, sampled on start |
| tx_dma_en_i | input | 1 | Enables the transmit DMA request |
| rx_dma_en_i | input | 1 | Enables the receive DMA request |
| poly_wr_i | input | 1 | Polynomial register write strobe |
| poly_i | input | DW | Polynomial write data |
| err_clr_i | input | 1 | Write-one pulse that clears crc_err_o |
| tx_wr_i | input | 1 | Write strobe to the transmit holding register |
| tx_data_i | input | DW | Transmit write data |
| tx_req_o | output | 1 | Transmit DMA request |
| eng_tx_valid_o | output | 1 | Word offered to the shift engine |
| eng_tx_data_o | output | DW | Word for the shift engine |
| eng_tx_ready_i | input | 1 | Shift engine accepts the offered word |
| eng_rx_valid_i | input | 1 | Shift engine returns a received word |
| eng_rx_data_i | input | DW | Received word |
| rx_rd_i | input | 1 | Read strobe of the receive data register |
| rx_data_o | output | DW | Receive data register |
| rx_full_o | output | 1 | Receive buffer full flag |
| rx_req_o | output | 1 | Receive DMA request |
| crc_err_o | output | 1 | Sticky CRC mismatch flag |
| half_irq_o | output | 1 | Half-count interrupt pulse |
| done_irq_o | output | 1 | Transfer-complete interrupt pulse |
| busy_o | output | 1 | Transfer active |

## Verification
The symptoms of a wrong internal state depend on where the fault is.

- A wrong payload counter shows up at once as an extra or missing transmit request. The bench counts DMA writes and engine words per transfer, so it catches this by the end of the transfer.
- A transmit accumulator that is not cleared, or that is updated at the wrong moment, corrupts the appended CRC word. That word arrives at rx_data_o a few cycles after the last payload word and is compared there.
- A receive-side fault shows up as a false or missing crc_err_o, or as a misplaced interrupt pulse. The bench counts both interrupt pulses on every transfer.
- A stale accumulator carried from one transfer to the next shows up only in the second transfer, so back-to-back transfers are run.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned LEN_W_DEF  = 8;
  localparam logic [7:0]  POLY_DEF   = 8'h07;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_PAY  = 2'd1,
    TXS_CRC  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/spi_crc_acc.sv
module spi_crc_acc #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          upd_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] poly_i,
  output logic [DW-1:0] crc_o
);
  // bit-serial CRC, MSB of the data word first
  function automatic logic [DW-1:0] crc_next(input logic [DW-1:0] c,
                                             input logic [DW-1:0] d,
                                             input logic [DW-1:0] p);
    logic [DW-1:0] r;
    logic          fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[DW-1] ^ d[i];
      r  = {r[DW-2:0], 1'b0};
      if (fb) r = r ^ p;
    end
    return r;
  endfunction

  logic [DW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (upd_i) acc_q <= crc_next(acc_q, din_i, poly_i);
  end

  assign crc_o = acc_q;

  AST_CRC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == '0)); // R8
endmodule

// File: rtl/spi_tx_seq.sv
module spi_tx_seq
  import spi_dma_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          crc_en_i,
  input  logic          dma_en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] crc_val_i,
  input  logic          eng_ready_i,
  output logic          eng_valid_o,
  output logic [DW-1:0] eng_data_o,
  output logic          req_o,
  output logic          acc_upd_o,
  output logic [DW-1:0] acc_din_o,
  output logic          tx_end_o
);
  tx_state_e     st_q;
  logic [LW-1:0] remain_q;
  logic          full_q;
  logic [DW-1:0] hold_q;

  logic wr_ok;
  logic hand;
  logic last_pay_hand;
  logic crc_hand;

  assign wr_ok         = (st_q == TXS_PAY) && !full_q && (remain_q != '0) && wr_i;
  assign eng_valid_o   = ((st_q == TXS_PAY) && full_q) || (st_q == TXS_CRC);
  assign eng_data_o    = (st_q == TXS_CRC) ? crc_val_i : hold_q;
  assign hand          = eng_valid_o && eng_ready_i;
  assign last_pay_hand = hand && (st_q == TXS_PAY) && (remain_q == '0);
  assign crc_hand      = hand && (st_q == TXS_CRC);
  assign req_o         = dma_en_i && (st_q == TXS_PAY) && !full_q && (remain_q != '0);
  assign acc_upd_o     = hand && (st_q == TXS_PAY);
  assign acc_din_o     = hold_q;
  assign tx_end_o      = crc_hand || (last_pay_hand && !crc_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= TXS_IDLE;
      remain_q <= '0;
      full_q   <= 1'b0;
      hold_q   <= '0;
    end else if (start_i) begin
      st_q     <= TXS_PAY;
      remain_q <= len_i;
      full_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        hold_q   <= wdata_i;
        full_q   <= 1'b1;
        remain_q <= remain_q - 1'b1;
      end
      if (hand && (st_q == TXS_PAY)) full_q <= 1'b0;
      if (last_pay_hand) st_q <= crc_en_i ? TXS_CRC : TXS_IDLE;
      if (crc_hand) st_q <= TXS_IDLE;
    end
  end

  AST_NO_TXREQ_IN_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TXS_CRC) |-> !req_o); // R2
  AST_CRC_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pay_hand && crc_en_i && !start_i) |=> (eng_valid_o && (eng_data_o == crc_val_i))); // R3
  AST_WR_IGNORED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !start_i && !hand) |=> ($stable(hold_q) && $stable(remain_q))); // R2
endmodule

// File: rtl/spi_rx_seq.sv
module spi_rx_seq #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          crc_en_i,
  input  logic          dma_en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_i,
  input  logic          err_clr_i,
  input  logic [DW-1:0] crc_val_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          req_o,
  output logic          crc_err_o,
  output logic          half_o,
  output logic          done_o,
  output logic          acc_upd_o,
  output logic [DW-1:0] acc_din_o,
  output logic          rx_end_o
);
  function automatic logic [LW-1:0] half_mark(input logic [LW-1:0] n);
    return n >> 1;
  endfunction

  logic          active_q;
  logic          wait_crc_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] rdata_q;
  logic          full_q;
  logic          err_q;
  logic          half_q;
  logic          done_q;

  logic          take;
  logic          pay_take;
  logic          crc_take;
  logic [LW-1:0] cnt_nx;
  logic          pay_last;
  logic          hit_half;
  logic          mismatch;

  assign take     = active_q && valid_i;
  assign pay_take = take && !wait_crc_q;
  assign crc_take = take && wait_crc_q;
  assign cnt_nx   = cnt_q + 1'b1;
  assign pay_last = pay_take && (cnt_nx == len_i);
  assign hit_half = pay_take && (half_mark(len_i) != '0) && (cnt_nx == half_mark(len_i));
  assign mismatch = crc_take && (data_i != crc_val_i);

  assign acc_upd_o = pay_take;
  assign acc_din_o = data_i;
  assign rx_end_o  = crc_take || (pay_last && !crc_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      wait_crc_q <= 1'b0;
      cnt_q      <= '0;
    end else if (start_i) begin
      active_q   <= 1'b1;
      wait_crc_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (pay_take) cnt_q <= cnt_nx;
      if (pay_last && crc_en_i) wait_crc_q <= 1'b1;
      if (rx_end_o) begin
        active_q   <= 1'b0;
        wait_crc_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
    end else if (take) begin
      rdata_q <= data_i;
      full_q  <= 1'b1;
    end else if (rd_i) begin
      full_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (mismatch)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      half_q <= hit_half;
      done_q <= rx_end_o;
    end
  end

  assign rdata_o   = rdata_q;
  assign full_o    = full_q;
  assign req_o     = dma_en_i && full_q;
  assign crc_err_o = err_q;
  assign half_o    = half_q;
  assign done_o    = done_q;

  AST_RX_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (full_o && (rdata_o == $past(data_i)))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err_o && !err_clr_i) |=> crc_err_o); // R6
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half_o, done_o})); // R7
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !take) |=> !full_o); // R5
endmodule

// File: rtl/spi_dma_seq.sv
module spi_dma_seq
  import spi_dma_pkg::*;
#(
  parameter int unsigned DW = DATA_W_DEF,
  parameter int unsigned LW = LEN_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          crc_en_i,
  input  logic          tx_dma_en_i,
  input  logic          rx_dma_en_i,
  input  logic          poly_wr_i,
  input  logic [DW-1:0] poly_i,
  input  logic          err_clr_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_req_o,
  output logic          eng_tx_valid_o,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_tx_ready_i,
  input  logic          eng_rx_valid_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          rx_req_o,
  output logic          crc_err_o,
  output logic          half_irq_o,
  output logic          done_irq_o,
  output logic          busy_o
);
  localparam logic [DW-1:0] POLY_RST = DW'(POLY_DEF);

  logic          busy_q;
  logic [LW-1:0] len_q;
  logic          crc_en_q;
  logic [DW-1:0] poly_q;

  // named internal events
  logic          start_ok;
  logic          tx_end;
  logic          rx_end;
  logic          tx_acc_upd;
  logic [DW-1:0] tx_acc_din;
  logic [DW-1:0] tx_crc;
  logic          rx_acc_upd;
  logic [DW-1:0] rx_acc_din;
  logic [DW-1:0] rx_crc;

  assign start_ok = start_i && !busy_q && (len_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      len_q    <= '0;
      crc_en_q <= 1'b0;
    end else if (start_ok) begin
      busy_q   <= 1'b1;
      len_q    <= len_i;
      crc_en_q <= crc_en_i;
    end else if (rx_end) begin
      busy_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    poly_q <= POLY_RST;
    else if (poly_wr_i && !busy_q) poly_q <= poly_i;
  end

  spi_crc_acc #(.DW(DW)) u_tx_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_ok || tx_end),
    .upd_i  (tx_acc_upd),
    .din_i  (tx_acc_din),
    .poly_i (poly_q),
    .crc_o  (tx_crc)
  );

  spi_crc_acc #(.DW(DW)) u_rx_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start_ok || rx_end),
    .upd_i  (rx_acc_upd),
    .din_i  (rx_acc_din),
    .poly_i (poly_q),
    .crc_o  (rx_crc)
  );

  spi_tx_seq #(.DW(DW), .LW(LW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_ok),
    .len_i       (len_i),
    .crc_en_i    (crc_en_q),
    .dma_en_i    (tx_dma_en_i),
    .wr_i        (tx_wr_i),
    .wdata_i     (tx_data_i),
    .crc_val_i   (tx_crc),
    .eng_ready_i (eng_tx_ready_i),
    .eng_valid_o (eng_tx_valid_o),
    .eng_data_o  (eng_tx_data_o),
    .req_o       (tx_req_o),
    .acc_upd_o   (tx_acc_upd),
    .acc_din_o   (tx_acc_din),
    .tx_end_o    (tx_end)
  );

  spi_rx_seq #(.DW(DW), .LW(LW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_ok),
    .len_i     (len_q),
    .crc_en_i  (crc_en_q),
    .dma_en_i  (rx_dma_en_i),
    .valid_i   (eng_rx_valid_i),
    .data_i    (eng_rx_data_i),
    .rd_i      (rx_rd_i),
    .err_clr_i (err_clr_i),
    .crc_val_i (rx_crc),
    .rdata_o   (rx_data_o),
    .full_o    (rx_full_o),
    .req_o     (rx_req_o),
    .crc_err_o (crc_err_o),
    .half_o    (half_irq_o),
    .done_o    (done_irq_o),
    .acc_upd_o (rx_acc_upd),
    .acc_din_o (rx_acc_din),
    .rx_end_o  (rx_end)
  );

  assign busy_o = busy_q;

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |-> !busy_o); // R7
  AST_POLY_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(poly_q)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rx_end) |=> ($stable(len_q) && busy_q)); // R10
  AST_TXREQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> busy_o); // R2
endmodule

// File: tb/spi_dma_seq_tb.sv
module spi_dma_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic       crc_en_i = 1'b0;
  logic       tx_dma_en_i = 1'b1;
  logic       rx_dma_en_i = 1'b1;
  logic       poly_wr_i = 1'b0;
  logic [7:0] poly_i = '0;
  logic       err_clr_i = 1'b0;
  logic       tx_wr_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_req_o;
  logic       eng_tx_valid_o;
  logic [7:0] eng_tx_data_o;
  logic       eng_tx_ready_i = 1'b0;
  logic       eng_rx_valid_i = 1'b0;
  logic [7:0] eng_rx_data_i = '0;
  logic       rx_rd_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_full_o;
  logic       rx_req_o;
  logic       crc_err_o;
  logic       half_irq_o;
  logic       done_irq_o;
  logic       busy_o;

  always #2 clk = ~clk;

  spi_dma_seq dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;

  // scoreboard and bench state
  logic [7:0] exp_q[$];
  logic [7:0] src[0:63];
  int   src_len = 0;
  int   ptr = 0;
  int   wr_cnt = 0;
  int   eng_cnt = 0;
  int   corrupt_idx = -1;
  int   half_cnt = 0;
  int   done_cnt = 0;
  bit   stray_wr = 1'b0;
  bit   manual_rd = 1'b0;
  logic [7:0] cur_poly = 8'h07;
  logic [7:0] hold;
  int   dly = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference CRC: fold the whole word in, then shift out the bits
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d,
                                         input logic [7:0] p);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ p) : (r << 1);
    return r;
  endfunction

  // DMA transmit driver
  always @(negedge clk) begin
    tx_wr_i = 1'b0;
    if (stray_wr) begin
      tx_wr_i = 1'b1; tx_data_i = 8'hAA; stray_wr = 1'b0;
    end else if (tx_req_o && ptr < src_len) begin
      tx_wr_i = 1'b1; tx_data_i = src[ptr]; ptr++; wr_cnt++;
    end
  end

  // behavioural shift engine, loops each word back after a delay
  always @(negedge clk) begin
    eng_rx_valid_i = 1'b0;
    if (eng_tx_ready_i) begin
      eng_tx_ready_i = 1'b0; dly = 3;
    end else if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        eng_rx_valid_i = 1'b1;
        eng_rx_data_i  = hold ^ ((eng_cnt == corrupt_idx) ? 8'h01 : 8'h00);
        eng_cnt++;
      end
    end else if (eng_tx_valid_o) begin
      eng_tx_ready_i = 1'b1; hold = eng_tx_data_o;
    end
  end

  // monitor: interrupt counters and receive scoreboard
  always @(negedge clk) begin
    if (half_irq_o) half_cnt++;
    if (done_irq_o) begin
      done_cnt++;
      check(!busy_o, "R7 busy low at done", busy_o, 0);
    end
    rx_rd_i = 1'b0;
    if (manual_rd) begin
      rx_rd_i = 1'b1; manual_rd = 1'b0;
    end else if (rx_req_o) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected rx word", rx_data_o, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(rx_data_o == e, "R5/R3/R4 rx word", rx_data_o, e);
      end
      rx_rd_i = 1'b1;
    end
  end

  task automatic wait_done(input int limit);
    int c = 0;
    while (done_cnt == 0 && c < limit) begin @(negedge clk); c++; end
    check(done_cnt == 1, "R7 done pulse (watchdog)", done_cnt, 1);
    repeat (4) @(negedge clk);
  endtask

  // run a transfer; src[] must be filled. crc_fix >= 0 overrides the CRC expectation
  task automatic xfer(input int n, input bit crc, input int cidx, input int crc_fix,
                      input bit poly_busy_wr, input bit start_busy);
    logic [7:0] c = 8'h00;
    bit err_before = crc_err_o;
    bit exp_err;
    for (int i = 0; i < n; i++) begin
      c = ref_crc(c, src[i], cur_poly);
      exp_q.push_back(src[i] ^ ((i == cidx) ? 8'h01 : 8'h00));
    end
    if (crc) begin
      if (crc_fix >= 0) c = crc_fix[7:0];
      exp_q.push_back(c ^ ((cidx == n) ? 8'h01 : 8'h00));
    end
    exp_err = err_before || (crc && cidx >= 0 && cidx <= n);
    src_len = n; ptr = 0; wr_cnt = 0; eng_cnt = 0; corrupt_idx = cidx;
    half_cnt = 0; done_cnt = 0;
    len_i = n[7:0]; crc_en_i = crc; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R10 start accepted", busy_o, 1);
    repeat (3) @(negedge clk);
    if (poly_busy_wr) begin
      poly_wr_i = 1'b1; poly_i = 8'hFF; @(negedge clk); poly_wr_i = 1'b0;
    end
    if (start_busy) begin
      len_i = 8'd7; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    end
    wait_done(4000);
    check(wr_cnt == n, "R2 writes accepted", wr_cnt, n);
    check(eng_cnt == n + int'(crc), "R3 engine words", eng_cnt, n + int'(crc));
    check(half_cnt == ((n >= 2) ? 1 : 0), "R7 half pulse", half_cnt, (n >= 2) ? 1 : 0);
    check(crc_err_o == exp_err, "R6 crc error flag", crc_err_o, exp_err);
    check(exp_q.size() == 0, "R5 all words read", exp_q.size(), 0);
    check(tx_req_o == 1'b0, "R2 no request after end", tx_req_o, 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    check(1'b0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check({tx_req_o, rx_req_o, rx_full_o, busy_o, crc_err_o, half_irq_o, done_irq_o,
           eng_tx_valid_o} == 8'h00, "R1 reset state",
          {tx_req_o, rx_req_o, rx_full_o, busy_o, crc_err_o, half_irq_o, done_irq_o,
           eng_tx_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_req_o == 1'b0, "R2 no request while idle", tx_req_o, 0);

    // R4 known check value "123456789" -> F4
    for (int i = 0; i < 9; i++) src[i] = 8'h31 + i[7:0];
    xfer(9, 1'b1, -1, 8'hF4, 1'b0, 1'b0);

    // R2 stray write while idle must not enter the payload
    stray_wr = 1'b1; @(negedge clk); @(negedge clk);
    for (int i = 0; i < 4; i++) src[i] = 8'h10 * i[7:0] + 8'h3;
    xfer(4, 1'b1, -1, -1, 1'b0, 1'b0);
    // R8 back to back, same payload again gives the same CRC
    xfer(4, 1'b1, -1, -1, 1'b0, 1'b0);

    // single word, no CRC; then odd length without CRC
    src[0] = 8'h5C;
    xfer(1, 1'b0, -1, -1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) src[i] = 8'hE1 - 8'd7 * i[7:0];
    xfer(5, 1'b0, -1, -1, 1'b0, 1'b0);

    // R10 start while busy ignored
    for (int i = 0; i < 3; i++) src[i] = 8'h99 ^ i[7:0];
    xfer(3, 1'b1, -1, -1, 1'b0, 1'b1);

    // R6 corrupted payload word and corrupted CRC word
    for (int i = 0; i < 2; i++) src[i] = 8'h42 + i[7:0];
    xfer(2, 1'b1, 0, -1, 1'b0, 1'b0);
    err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0;
    check(crc_err_o == 1'b0, "R6 write-one clear", crc_err_o, 0);
    xfer(2, 1'b1, 2, -1, 1'b0, 1'b0);
    err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0;

    // R5 CRC word parks in the register when receive DMA is off
    rx_dma_en_i = 1'b0;
    src_len = 1; ptr = 0; src[0] = 8'h01; done_cnt = 0; eng_cnt = 0; corrupt_idx = -1;
    len_i = 8'd1; crc_en_i = 1'b1; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_done(4000);
    check(rx_full_o == 1'b1, "R5 crc word sets full", rx_full_o, 1);
    check(rx_req_o == 1'b0, "R5 no request with dma off", rx_req_o, 0);
    check(rx_data_o == 8'h07, "R5 crc word in register", rx_data_o, 8'h07);
    manual_rd = 1'b1; @(negedge clk); @(negedge clk);
    check(rx_full_o == 1'b0, "R5 read clears full", rx_full_o, 0);
    rx_dma_en_i = 1'b1;

    // R10 zero length ignored
    len_i = 8'd0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    check({busy_o, tx_req_o} == 2'b00, "R10 zero length ignored", {busy_o, tx_req_o}, 0);

    // R9 polynomial write while idle takes effect, while busy is ignored
    poly_wr_i = 1'b1; poly_i = 8'h31; @(negedge clk); poly_wr_i = 1'b0;
    cur_poly = 8'h31;
    for (int i = 0; i < 6; i++) src[i] = 8'h0F + 8'd29 * i[7:0];
    xfer(6, 1'b1, -1, -1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule